// File: doc/BRIEF.md
# Single-Line Trigger-Selectable Interrupt Controller

This block watches one asynchronous interrupt line, such as a power-management alarm pin, and turns it into one interrupt request to the processor. Software picks how the line is read, as an active-low level, an active-high level, a falling edge or a rising edge. When the selected condition is seen, the block latches a pending flag. A mask bit decides whether that flag reaches the request output.

Software reaches the block through a plain register port: an address, a write strobe and 32-bit write and read data. Writes take effect on the clock edge. Reads are combinational from the address. Software acknowledges an event by writing 1 to the pending bit. In the level modes this write also ends the interrupt, so if the line is still active the flag sets again. The mask register sits at one of two offsets, and a parameter picks which one.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset the control, pending and enable registers all read 0 and `irq_out` is 0. The synchroniser starts at the idle (high) line level, so the default active-low mode raises nothing while the line stays high.
- R2: Control register at offset 0x00. Bits [1:0] hold the trigger mode: 0 = low level, 1 = falling edge, 2 = high level, 3 = rising edge. Written bits above [1:0] are dropped and read back as 0.
- R3: In mode 0, pending sets on every cycle in which the synchronised line is 0.
- R4: In mode 2, pending sets on every cycle in which the synchronised line is 1.
- R5: In mode 1, pending sets only on a 1-to-0 transition of the synchronised line. A line held at 0 does not set it again after a clear.
- R6: In mode 3, pending sets only on a 0-to-1 transition of the synchronised line. A line held at 1 does not set it again after a clear.
- R7: Pending register at offset 0x04, bit 0. Writing 1 to bit 0 clears the flag. Writing 0 leaves it unchanged.
- R8: When a set condition and a write-1 clear fall in the same cycle, the set wins and pending stays 1. This is how a level-mode acknowledge re-arms while the line is still active.
- R9: Enable register bit 0 sits at offset 0x08 when `ALT_MAP` = 0 and at offset 0x34 when `ALT_MAP` = 1. Pending sets whatever the enable value.
- R10: `irq_out` is a register. It equals pending AND enable as they were one clock earlier.
- R11: Any read of an offset that is not mapped returns 0. The offset of the other mapping variant counts as unmapped.
- R12: A change on `line_in` takes effect after two synchroniser flops. After the change, pending is 1 from the third rising clock edge onward, and never earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Asynchronous interrupt line |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that each write is a single-cycle strobe with a stable address, and that `line_in` holds each value for at least one clock. The bench therefore drives all inputs only on the falling clock edge. It holds the random line level for several cycles at a time, choosing each value with a low toggle probability. Random addresses come mostly from the mapped offsets, plus some drawn over the full range. This lets write-one clears collide with live set conditions under all four modes.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;

   typedef enum logic [1:0] {
      TRIG_LVL_LO  = 2'd0,
      TRIG_EDGE_FL = 2'd1,
      TRIG_LVL_HI  = 2'd2,
      TRIG_EDGE_RS = 2'd3
   } trig_mode_e;

   localparam logic [7:0] OFS_MODE   = 8'h00;
   localparam logic [7:0] OFS_PEND   = 8'h04;
   localparam logic [7:0] OFS_EN_STD = 8'h08;
   localparam logic [7:0] OFS_EN_ALT = 8'h34;

endpackage

// File: rtl/line_irq_sync.sv
module line_irq_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("line_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{IDLE}};
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/line_irq_detect.sv
module line_irq_detect
   import line_irq_pkg::*;
#(
   parameter logic IDLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  trig_mode_e mode,
   input  logic       lvl,
   output logic       hit
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= lvl;
   end

   always_comb begin
      unique case (mode)
         TRIG_LVL_LO:  hit = !lvl;
         TRIG_EDGE_FL: hit = prev_q && !lvl;
         TRIG_LVL_HI:  hit = lvl;
         TRIG_EDGE_RS: hit = !prev_q && lvl;
         default:      hit = 1'b0;
      endcase
   end

   // R5
   edge_fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRIG_EDGE_FL && hit) |=> !(mode == TRIG_EDGE_FL && hit));

endmodule

// File: rtl/line_irq_regs.sv
module line_irq_regs
   import line_irq_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit ALT_MAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              hit,
   output logic [DATA_W-1:0] rdata,
   output trig_mode_e        mode,
   output logic              pend,
   output logic              en
);

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_EN   = ALT_MAP ? ADDR_W'(OFS_EN_ALT) : ADDR_W'(OFS_EN_STD);

   if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
      $error("line_irq_regs: ADDR_W must be 6 to 8");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("line_irq_regs: DATA_W must be at least 2");
   end

   logic sel_mode, sel_pend, sel_en;
   logic unused_wbits;

   assign sel_mode     = (addr == A_MODE);
   assign sel_pend     = (addr == A_PEND);
   assign sel_en       = (addr == A_EN);
   assign unused_wbits = ^wdata[DATA_W-1:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= TRIG_LVL_LO;
         en   <= 1'b0;
      end else if (we) begin
         if (sel_mode) mode <= trig_mode_e'(wdata[1:0]);
         if (sel_en)   en   <= wdata[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         pend <= 1'b0;
      else if (hit)                       pend <= 1'b1;
      else if (we && sel_pend && wdata[0]) pend <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (sel_mode)      rdata[1:0] = mode;
      else if (sel_pend) rdata[0]   = pend;
      else if (sel_en)   rdata[0]   = en;
   end

   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && sel_mode) |=> $stable(mode));

   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel_pend && wdata[0] && !hit) |=> !pend);

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> pend);

   // R11
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_mode || sel_pend || sel_en) |-> (rdata == '0));

endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
   import line_irq_pkg::*;
#(
   parameter int   ADDR_W      = 8,
   parameter int   DATA_W      = 32,
   parameter bit   ALT_MAP     = 1'b0,
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LVL    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);

   logic       lvl_s, hit, pend, en;
   trig_mode_e mode;

   line_irq_sync #(.STAGES(SYNC_STAGES), .IDLE(IDLE_LVL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(line_in), .q_sync(lvl_s));

   line_irq_detect #(.IDLE(IDLE_LVL)) u_det (
      .clk(clk), .rst_n(rst_n), .mode(mode), .lvl(lvl_s), .hit(hit));

   line_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALT_MAP(ALT_MAP)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
      .hit(hit), .rdata(bus_rdata), .mode(mode), .pend(pend), .en(en));

   always_ff @(posedge clk) begin
      if (!rst_n) irq_out <= 1'b0;
      else        irq_out <= pend && en;
   end

   // R10
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && en) |=> irq_out);

   // R10
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !irq_out);

   // R9
   pend_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !en) |=> pend);

endmodule

// File: tb/sim_line_irq_ctrl.sv
module sim_line_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_in = 1'b1;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] rdata0, rdata1;
   logic        irq0, irq1;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   line_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata0), .irq_out(irq0));

   line_irq_ctrl #(.ALT_MAP(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .line_in(line_in),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
      .irq_out(irq1));

   // reference state of u0, built from the requirements
   logic       m_s1, m_s2, m_prev, m_pend, m_en, m_irq;
   logic [1:0] m_mode;

   function automatic logic fn_hit(logic [1:0] md, logic cur, logic prv);
      case (md)
         2'd0:    return !cur;
         2'd1:    return prv && !cur;
         2'd2:    return cur;
         default: return !prv && cur;
      endcase
   endfunction

   function automatic logic [31:0] fn_read(logic [7:0] a);
      if (a == 8'h00) return {30'h0, m_mode};
      if (a == 8'h04) return {31'h0, m_pend};
      if (a == 8'h08) return {31'h0, m_en};
      return 32'h0;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
         m_pend <= 1'b0; m_en <= 1'b0; m_irq <= 1'b0; m_mode <= 2'd0;
      end else begin
         m_s1   <= line_in;
         m_s2   <= m_s1;
         m_prev <= m_s2;
         m_irq  <= m_pend && m_en;
         if (fn_hit(m_mode, m_s2, m_prev))                m_pend <= 1'b1;
         else if (bus_we && bus_addr == 8'h04 && bus_wdata[0]) m_pend <= 1'b0;
         if (bus_we && bus_addr == 8'h00) m_mode <= bus_wdata[1:0];
         if (bus_we && bus_addr == 8'h08) m_en   <= bus_wdata[0];
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #1 chk(tag, rdata0, exp);
      chk({tag, " model"}, rdata0, fn_read(a));
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      #1;
      chk("R1 mode", rdata0, 32'h0);
      chk("R1 irq", {31'h0, irq0}, 32'h0);
      wait_cyc(4);
      rd("R1 pend idle", 8'h04, 32'h0);
      rd("R1 enable", 8'h08, 32'h0);
      // R12 + R3: low level, exact latency
      @(negedge clk); line_in = 1'b0; bus_addr = 8'h04;
      @(negedge clk); #1 chk("R12 after 1", rdata0, 32'h0);
      @(negedge clk); #1 chk("R12 after 2", rdata0, 32'h0);
      @(negedge clk); #1 chk("R12 R3 after 3", rdata0, 32'h1);
      // R8: clear while level still active
      wr(8'h04, 32'h1);
      rd("R8 set wins", 8'h04, 32'h1);
      line_in = 1'b1; wait_cyc(4);
      wr(8'h04, 32'h0);
      rd("R7 write 0 keeps", 8'h04, 32'h1);
      wr(8'h04, 32'h1);
      rd("R7 write 1 clears", 8'h04, 32'h0);
      // R2 upper bits dropped, R4 high level
      wr(8'h00, 32'hFFFF_FFFE);
      rd("R2 mode readback", 8'h00, 32'h2);
      wait_cyc(2);
      rd("R4 high level", 8'h04, 32'h1);
      line_in = 1'b0; wait_cyc(4);
      wr(8'h04, 32'h1);
      rd("R4 low line clears", 8'h04, 32'h0);
      // R6 rising edge, R9, R10
      wr(8'h00, 32'h3);
      wr(8'h08, 32'h1);
      rd("R9 enable std", 8'h08, 32'h1);
      @(negedge clk); line_in = 1'b1; bus_addr = 8'h04;
      wait_cyc(3); #1
      chk("R6 rise pend", rdata0, 32'h1);
      chk("R10 irq not yet", {31'h0, irq0}, 32'h0);
      @(negedge clk); #1 chk("R10 irq up", {31'h0, irq0}, 32'h1);
      wr(8'h04, 32'h1);
      wait_cyc(4);
      rd("R6 held high no reset", 8'h04, 32'h0);
      chk("R10 irq down", {31'h0, irq0}, 32'h0);
      // R5 falling edge with mask off
      wr(8'h08, 32'h0);
      wr(8'h00, 32'h1);
      line_in = 1'b0; wait_cyc(5);
      rd("R9 pend while masked", 8'h04, 32'h1);
      chk("R10 masked irq", {31'h0, irq0}, 32'h0);
      wr(8'h04, 32'h1);
      wait_cyc(4);
      rd("R5 held low no reset", 8'h04, 32'h0);
      // R11 and the alternate map
      rd("R11 unmapped 0x10", 8'h10, 32'h0);
      rd("R11 alt offset on std", 8'h34, 32'h0);
      wr(8'h34, 32'h1);
      @(negedge clk); bus_addr = 8'h34;
      #1 chk("R9 enable alt", rdata1, 32'h1);
      bus_addr = 8'h08;
      #1 chk("R11 std offset on alt", rdata1, 32'h0);
      // random phase against the model
      void'($urandom(32'd4711));
      for (int i = 0; i < 3000; i++) begin
         int unsigned r;
         @(negedge clk);
         r = $urandom;
         if (r[2:0] == 3'd0) line_in = ~line_in;
         bus_we = (r[5:4] == 2'd0);
         case (r[8:6])
            3'd0, 3'd1: bus_addr = 8'h04;
            3'd2:       bus_addr = 8'h00;
            3'd3:       bus_addr = 8'h08;
            3'd4:       bus_addr = 8'h34;
            default:    bus_addr = 8'($urandom);
         endcase
         bus_wdata = $urandom;
         #1;
         chk("R7 R11 random read", rdata0, fn_read(bus_addr));
         chk("R10 random irq", {31'h0, irq0}, {31'h0, m_irq});
      end
      bus_we = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule